// File: doc/BRIEF.md
# Register-Indirect Address Generator

This block produces data-memory addresses for a signal-processing data path. It keeps eight address registers and eight index registers, each 16 bits wide. On each accepted request it forms one effective address from a chosen address register and a modifier. The modifier is zero, one, an index register or an immediate offset. The block can also write an updated value back to that address register. The request carries three independent control bits that pick the behaviour:

- **Timing bit:** the register is modified either before or after it is used.
- **Update bit:** the modified value is either written back or discarded.
- **Direction bit:** the modifier is either added or subtracted.

Together these bits cover all of the following modes:

- plain indirect access
- step by one, before or after use
- step by an index register or by an immediate, before or after use
- offset access that leaves the register untouched

A load port writes any register directly. A request that modifies before use and writes back takes one cycle more than the other modes. While the result of such a request is pending, the unit does not accept a new request.

Top module: `dsp_agu`

## Requirements
- R1: After reset every address and index register reads as zero, `agu_ready` is 1 and `ea_valid` is 0.
- R2: A request with `req_pre`=0 and `req_upd`=1 presents the unmodified address register as `ea` with `ea_valid` high in the first cycle after the accepting clock edge. It writes the modified value back to that register.
- R3: A request with `req_pre`=1 and `req_upd`=1 writes the modified value back and presents that same value on `ea` in the second cycle after the accepting edge. In the first cycle after that edge, `ea_valid` is 0 and `agu_ready` is 0.
- R4: A request with `req_upd`=0 leaves the address register unchanged. It presents `ea` one cycle after acceptance: the modified value when `req_pre`=1, and the unmodified register when `req_pre`=0.
- R5: `req_src` selects the modifier: 0 gives zero, 1 gives one, 2 gives the index register chosen by `req_xsel`, and 3 gives `req_imm`.
- R6: When `req_sub`=1 the modifier is subtracted from the address register; when it is 0 the modifier is added.
- R7: All address arithmetic wraps modulo 2^16.
- R8: A load (`ld_en`=1) writes `ld_data` into the address bank when `ld_bank`=0, or into the index bank when it is 1, at entry `ld_sel`. When a load and a write-back hit the same address register on the same edge, the register takes the loaded value.
- R9: A request presented while `agu_ready` is 0 is ignored: it produces no `ea_valid` pulse and makes no write-back.
- R10: Every accepted request produces exactly one `ea_valid` pulse, and `ea_valid` is never high without a preceding accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_asel | input | 3 | Address register used as base and write-back target |
| req_xsel | input | 3 | Index register used as modifier when `req_src`=2 |
| req_pre | input | 1 | 1 = modify before use, 0 = after use |
| req_upd | input | 1 | 1 = write modified value back |
| req_sub | input | 1 | 1 = subtract modifier, 0 = add |
| req_src | input | 2 | Modifier source: 0 zero, 1 one, 2 index register, 3 immediate |
| req_imm | input | 16 | Immediate offset |
| ld_en | input | 1 | Register load strobe |
| ld_bank | input | 1 | 0 = address bank, 1 = index bank |
| ld_sel | input | 3 | Register entry to load |
| ld_data | input | 16 | Value to load |
| agu_ready | output | 1 | Unit accepts a request this cycle |
| ea_valid | output | 1 | Effective address strobe |
| ea | output | 16 | Effective address |

## Verification
The hardest situation to reach from the ports is a request that arrives while a pre-modify result is still pending. The same is true of a load that lands on the address register being written back on the same edge. Directed sequences set up both cases on purpose. A pre-modify request is issued and another request is held on the next cycle, and a load is paired with a write-back to the same entry. After that, a long randomised stream mixes loads, every modifier source and every control-bit combination, so back-to-back pre-modify requests and near-wrap values occur often. A behavioural model checks every cycle of that stream.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic [1:0] {
    MOD_ZERO  = 2'd0,
    MOD_ONE   = 2'd1,
    MOD_INDEX = 2'd2,
    MOD_IMM   = 2'd3
  } mod_src_e;

  typedef struct packed {
    logic     pre;
    logic     upd;
    logic     sub;
    mod_src_e src;
  } agu_mode_t;

endpackage

// File: rtl/agu_regfile.sv
module agu_regfile #(
  parameter int NREG  = 8,
  parameter int WIDTH = 16,
  localparam int SW   = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wb_en,
  input  logic [SW-1:0]    wb_sel,
  input  logic [WIDTH-1:0] wb_data,
  input  logic             ld_en,
  input  logic             ld_bank,
  input  logic [SW-1:0]    ld_sel,
  input  logic [WIDTH-1:0] ld_data,
  input  logic [SW-1:0]    rd_a_sel,
  input  logic [SW-1:0]    rd_x_sel,
  output logic [WIDTH-1:0] rd_a,
  output logic [WIDTH-1:0] rd_x
);

  logic [NREG-1:0][WIDTH-1:0] areg_q;
  logic [NREG-1:0][WIDTH-1:0] xreg_q;

  // named events for the checks below
  logic ld_abank;
  logic ld_xbank;
  logic wb_ld_collide;
  assign ld_abank      = ld_en && !ld_bank;
  assign ld_xbank      = ld_en &&  ld_bank;
  assign wb_ld_collide = ld_abank && wb_en && (ld_sel == wb_sel);

  for (genvar g = 0; g < NREG; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        areg_q[g] <= '0;
      end else if (ld_abank && ld_sel == SW'(g)) begin
        areg_q[g] <= ld_data;            // load outranks write-back (R8)
      end else if (wb_en && wb_sel == SW'(g)) begin
        areg_q[g] <= wb_data;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        xreg_q[g] <= '0;
      end else if (ld_xbank && ld_sel == SW'(g)) begin
        xreg_q[g] <= ld_data;
      end
    end
  end

  assign rd_a = areg_q[rd_a_sel];
  assign rd_x = xreg_q[rd_x_sel];

  a_r8_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wb_ld_collide |=> areg_q[$past(ld_sel)] == $past(ld_data));

  a_r4_bank_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!wb_en && !ld_abank) |=> $stable(areg_q));

  a_r8_index_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_xbank |=> $stable(xreg_q));

endmodule

// File: rtl/agu_ctrl.sv
module agu_ctrl
  import agu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  agu_mode_t        mode,
  input  logic [WIDTH-1:0] base,
  input  logic [WIDTH-1:0] index_val,
  input  logic [WIDTH-1:0] imm,
  output logic             wb_en,
  output logic [WIDTH-1:0] wb_data,
  output logic             ready,
  output logic             ea_valid,
  output logic [WIDTH-1:0] ea
);

  // modifier selection (R5)
  function automatic logic [WIDTH-1:0] pick_modifier(
    input mod_src_e         src,
    input logic [WIDTH-1:0] xv,
    input logic [WIDTH-1:0] iv
  );
    case (src)
      MOD_ZERO:  return '0;
      MOD_ONE:   return WIDTH'(1);
      MOD_INDEX: return xv;
      default:   return iv;
    endcase
  endfunction

  // add or subtract, wrapping at the register width (R6, R7)
  function automatic logic [WIDTH-1:0] step_addr(
    input logic [WIDTH-1:0] b,
    input logic [WIDTH-1:0] m,
    input logic             sub
  );
    return sub ? (b - m) : (b + m);
  endfunction

  logic             busy_q;
  logic [WIDTH-1:0] hold_q;
  logic             ea_valid_q;
  logic [WIDTH-1:0] ea_q;

  logic             accept;
  logic             accept_pre_upd;
  logic             accept_direct;
  logic [WIDTH-1:0] modifier;
  logic [WIDTH-1:0] modified;
  logic [WIDTH-1:0] direct_ea;

  assign accept         = req_valid && !busy_q;
  assign accept_pre_upd = accept && mode.pre && mode.upd;
  assign accept_direct  = accept && !(mode.pre && mode.upd);
  assign modifier       = pick_modifier(mode.src, index_val, imm);
  assign modified       = step_addr(base, modifier, mode.sub);
  assign direct_ea      = mode.pre ? modified : base;

  assign wb_en   = accept && mode.upd;
  assign wb_data = modified;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      hold_q     <= '0;
      ea_valid_q <= 1'b0;
      ea_q       <= '0;
    end else begin
      ea_valid_q <= 1'b0;
      if (busy_q) begin
        ea_q       <= hold_q;
        ea_valid_q <= 1'b1;
        busy_q     <= 1'b0;
      end else if (accept_pre_upd) begin
        hold_q <= modified;
        busy_q <= 1'b1;
      end else if (accept_direct) begin
        ea_q       <= direct_ea;
        ea_valid_q <= 1'b1;
      end
    end
  end

  assign ready    = !busy_q;
  assign ea_valid = ea_valid_q;
  assign ea       = ea_q;

  a_r3_stall_slot: assert property (@(posedge clk) disable iff (!rst_n)
    accept_pre_upd |=> (!ready && !ea_valid));

  a_r3_late_result: assert property (@(posedge clk) disable iff (!rst_n)
    accept_pre_upd |=> ##1 (ea_valid && ea == $past(modified, 2)));

  a_r2_post_base: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !mode.pre) |=> (ea_valid && ea == $past(base)));

  a_r4_pre_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && mode.pre && !mode.upd) |=> (ea_valid && ea == $past(modified)));

  a_r9_no_wb_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !wb_en);

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ea_valid |=> !ea_valid || $past(accept));

endmodule

// File: rtl/dsp_agu.sv
module dsp_agu
  import agu_pkg::*;
#(
  parameter int NREG  = 8,
  parameter int WIDTH = 16,
  localparam int SW   = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [SW-1:0]    req_asel,
  input  logic [SW-1:0]    req_xsel,
  input  logic             req_pre,
  input  logic             req_upd,
  input  logic             req_sub,
  input  logic [1:0]       req_src,
  input  logic [WIDTH-1:0] req_imm,
  input  logic             ld_en,
  input  logic             ld_bank,
  input  logic [SW-1:0]    ld_sel,
  input  logic [WIDTH-1:0] ld_data,
  output logic             agu_ready,
  output logic             ea_valid,
  output logic [WIDTH-1:0] ea
);

  agu_mode_t        mode;
  logic [WIDTH-1:0] base_val;
  logic [WIDTH-1:0] index_val;
  logic             wb_en;
  logic [WIDTH-1:0] wb_data;

  assign mode.pre = req_pre;
  assign mode.upd = req_upd;
  assign mode.sub = req_sub;
  assign mode.src = mod_src_e'(req_src);

  agu_regfile #(.NREG(NREG), .WIDTH(WIDTH)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wb_en    (wb_en),
    .wb_sel   (req_asel),
    .wb_data  (wb_data),
    .ld_en    (ld_en),
    .ld_bank  (ld_bank),
    .ld_sel   (ld_sel),
    .ld_data  (ld_data),
    .rd_a_sel (req_asel),
    .rd_x_sel (req_xsel),
    .rd_a     (base_val),
    .rd_x     (index_val)
  );

  agu_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .mode      (mode),
    .base      (base_val),
    .index_val (index_val),
    .imm       (req_imm),
    .wb_en     (wb_en),
    .wb_data   (wb_data),
    .ready     (agu_ready),
    .ea_valid  (ea_valid),
    .ea        (ea)
  );

  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (!ea_valid && agu_ready));

endmodule

// File: tb/sim_dsp_agu.sv
`timescale 1ns/1ps
module sim_dsp_agu;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_asel = '0;
  logic [2:0]  req_xsel = '0;
  logic        req_pre = 1'b0;
  logic        req_upd = 1'b0;
  logic        req_sub = 1'b0;
  logic [1:0]  req_src = '0;
  logic [15:0] req_imm = '0;
  logic        ld_en = 1'b0;
  logic        ld_bank = 1'b0;
  logic [2:0]  ld_sel = '0;
  logic [15:0] ld_data = '0;
  logic        agu_ready;
  logic        ea_valid;
  logic [15:0] ea;

  always #2.5 clk = ~clk;   // 200 MHz

  dsp_agu u0 (.*);

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  // behavioural reference
  logic [15:0] m_a [8];
  logic [15:0] m_x [8];
  bit          m_pend;
  logic [15:0] m_pend_ea;
  string       m_pend_tag;
  bit          m_v;
  logic [15:0] m_ea;
  string       m_tag;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h at cycle %0d", tag, got, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      foreach (m_a[k]) begin m_a[k] = '0; m_x[k] = '0; end
      m_pend = 0; m_v = 0; m_ea = '0; m_tag = "R1";
    end else begin
      logic [15:0] md, nv;
      m_v = 0;
      if (m_pend) begin
        m_v = 1; m_ea = m_pend_ea; m_tag = m_pend_tag; m_pend = 0;
      end else if (req_valid) begin
        case (req_src)
          2'd0: md = 16'd0;
          2'd1: md = 16'd1;
          2'd2: md = m_x[req_xsel];
          default: md = req_imm;
        endcase
        nv = req_sub ? 16'(m_a[req_asel] - md) : 16'(m_a[req_asel] + md);
        if (req_pre && req_upd) begin
          m_pend = 1; m_pend_ea = nv; m_pend_tag = "R3";
        end else begin
          m_v = 1; m_ea = req_pre ? nv : m_a[req_asel];
          m_tag = req_upd ? "R2" : "R4";
        end
        if (req_upd) m_a[req_asel] = nv;
      end
      if (ld_en) begin
        if (ld_bank) m_x[ld_sel] = ld_data;
        else         m_a[ld_sel] = ld_data;
      end
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R10", ea_valid, m_v);
      chk("R9", agu_ready, !m_pend);
      if (m_v && ea_valid) chk(m_tag, ea, m_ea);
    end
  end

  task automatic idle();
    req_valid = 0; ld_en = 0;
  endtask

  task automatic load(input bit bank, input int sel, input logic [15:0] d);
    ld_en = 1; ld_bank = bank; ld_sel = 3'(sel); ld_data = d;
    @(negedge clk); idle();
  endtask

  // issue one request; returns on the negedge after the accepting edge
  task automatic issue(input int a, input int x, input bit pre, input bit upd,
                       input bit sub, input int src, input logic [15:0] imm);
    req_valid = 1; req_asel = 3'(a); req_xsel = 3'(x); req_pre = pre;
    req_upd = upd; req_sub = sub; req_src = 2'(src); req_imm = imm;
    @(negedge clk); idle();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", {agu_ready, ea_valid}, 2'b10);
    issue(5, 0, 0, 0, 0, 0, 0);               // plain read of reset value
    chk("R1", ea, 16'h0000);

    load(0, 0, 16'h0010); load(1, 0, 16'h0004);
    issue(0, 0, 0, 1, 0, 1, 0);               // post +1
    chk("R2", {ea_valid, ea}, {1'b1, 16'h0010});
    issue(0, 0, 1, 1, 1, 1, 0);               // pre -1
    chk("R3", {ea_valid, agu_ready}, 2'b00);
    @(negedge clk);
    chk("R3", {ea_valid, ea}, {1'b1, 16'h0010});
    chk("R6", agu_ready, 1'b1);
    issue(0, 0, 1, 0, 0, 2, 0);               // offset by index, no update
    chk("R5", ea, 16'h0014);
    issue(0, 0, 0, 0, 0, 0, 0);
    chk("R4", ea, 16'h0010);
    issue(0, 0, 1, 0, 1, 3, 16'h0020);        // immediate subtract, wraps
    chk("R7", ea, 16'hFFF0);

    load(0, 1, 16'hFFFF);
    issue(1, 0, 0, 1, 0, 1, 0);
    issue(1, 0, 0, 0, 0, 0, 0);
    chk("R7", ea, 16'h0000);

    // load and write-back on the same entry and edge
    ld_en = 1; ld_bank = 0; ld_sel = 3'd2; ld_data = 16'h1234;
    issue(2, 0, 0, 1, 0, 3, 16'h0100);
    issue(2, 0, 0, 0, 0, 0, 0);
    chk("R8", ea, 16'h1234);

    // request during the stall slot is dropped
    load(0, 3, 16'h0040);
    issue(3, 0, 1, 1, 0, 1, 0);
    req_valid = 1; req_asel = 3'd3; req_pre = 0; req_upd = 1; req_src = 2'd1; req_sub = 0;
    @(negedge clk); idle();
    chk("R9", {ea_valid, ea}, {1'b1, 16'h0041});
    issue(3, 0, 0, 0, 0, 0, 0);
    chk("R9", ea, 16'h0041);
    @(negedge clk);
    chk("R10", ea_valid, 1'b0);

    // randomised stream
    for (int i = 0; i < 4000; i++) begin
      req_valid = ($urandom_range(0, 3) != 0);
      req_asel  = 3'($urandom); req_xsel = 3'($urandom);
      req_pre   = 1'($urandom); req_upd  = 1'($urandom);
      req_sub   = 1'($urandom); req_src  = 2'($urandom);
      req_imm   = ($urandom_range(0, 3) == 0) ? 16'hFFFF : 16'($urandom);
      ld_en     = ($urandom_range(0, 4) == 0);
      ld_bank   = 1'($urandom); ld_sel = 3'($urandom);
      ld_data   = ($urandom_range(0, 3) == 0) ? 16'hFFFE : 16'($urandom);
      @(negedge clk);
    end
    idle();
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule